// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor built around a single accumulator. It runs every instruction as a fixed sequence of register transfers, one transfer step per clock. The sequence fetches the instruction word, decodes it, reads the operand from memory, executes the operation and, where needed, writes the result back.

All memory traffic goes through two registers. An address-holding register drives the address bus. A data-holding register carries the words that are read or written. A temporary register keeps each memory operand until the arithmetic unit combines it with the accumulator.

The core connects to one word-addressed memory. That memory returns read data one clock after it sees the read strobe, and it accepts a write in the same cycle as the write strobe. A halt output tells the surrounding system that the core has stopped. A separate flag tells it that the stop was caused by an undefined opcode.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears these outputs and registers:
  - `mem_rd`, `mem_wr`, `halted` and `illegal` go to 0.
  - `mem_addr` goes to 0.
  - The accumulator goes to 0.
  - The program counter loads `START_ADDR`, so the first instruction read after reset comes from `START_ADDR`.
- R2: Each instruction is read with one read-strobe cycle at the program counter. Without a jump, consecutive instruction reads come from consecutive addresses.
- R3: An instruction word carries the opcode in bits [15:12] and a direct address in bits [11:0]. The opcodes are:
  - 0: stop.
  - 1: load.
  - 2: add.
  - 3: multiply.
  - 4: store.
  - 5: jump.
- R4: Load (opcode 1) replaces the accumulator with the word at the given address.
- R5: Add (opcode 2) sets the accumulator to the accumulator plus the word at the given address, modulo 2^16.
- R6: Multiply (opcode 3) sets the accumulator to the low 16 bits of the accumulator times the word at the given address.
- R7: Store (opcode 4) drives the accumulator on `mem_wdata` and the given address on `mem_addr` with `mem_wr` high for exactly one cycle.
- R8: Jump (opcode 5) reads no operand and writes nothing. The next instruction read comes from the given address.
- R9: Instruction lengths are fixed:
  - Load, add and multiply take 6 cycles.
  - Store takes 5 cycles.
  - Jump takes 4 cycles.
  - Opcode 0 or an undefined opcode asserts `halted` 3 cycles after its fetch begins.
- R10: After opcode 0, `halted` rises with `illegal` low. From then until reset, `halted` stays high and the core makes no memory access.
- R11: Any opcode from 6 to 15 sets both `illegal` and `halted`, and they stay set until reset.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle, and `mem_rd` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an undefined opcode |

## Verification
The bound checker watches the bus rules on every cycle:
- Read and write never overlap.
- There are no back-to-back reads.
- Each write lasts a single cycle and comes three cycles after the fetch read that started the store instruction.
- Once stopped, the core stays stopped and silent, and an undefined-opcode stop always shows as a stop.

Only the bench's program runs can show the following:
- Arithmetic results, including wrap-around and product truncation.
- The order of instruction addresses and the redirect after a jump.
- Reset values seen through a store.
- Per-instruction cycle counts.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [2:0] {
      ST_FETCH_ADDR,
      ST_FETCH_WAIT,
      ST_DECODE,
      ST_OPERAND_ADDR,
      ST_OPERAND_WAIT,
      ST_EXECUTE,
      ST_STORE,
      ST_HALT
   } cpu_state_e;

   localparam logic [OPC_W-1:0] OPC_STOP = 4'd0;
   localparam logic [OPC_W-1:0] OPC_LOAD = 4'd1;
   localparam logic [OPC_W-1:0] OPC_ADD  = 4'd2;
   localparam logic [OPC_W-1:0] OPC_MUL  = 4'd3;
   localparam logic [OPC_W-1:0] OPC_STOR = 4'd4;
   localparam logic [OPC_W-1:0] OPC_JUMP = 4'd5;

   function automatic logic opc_defined(input logic [OPC_W-1:0] opc);
      return opc <= OPC_JUMP;
   endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OPC_W-1:0] fetched_opc,
   input  logic [OPC_W-1:0] held_opc,
   output cpu_state_e       state,
   output logic             bad_opc
);

   cpu_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_FETCH_ADDR:   state_nx = ST_FETCH_WAIT;
         ST_FETCH_WAIT:   state_nx = ST_DECODE;
         ST_DECODE: begin
            case (fetched_opc)
               OPC_LOAD, OPC_ADD, OPC_MUL: state_nx = ST_OPERAND_ADDR;
               OPC_STOR, OPC_JUMP:         state_nx = ST_EXECUTE;
               default:                    state_nx = ST_HALT;
            endcase
         end
         ST_OPERAND_ADDR: state_nx = ST_OPERAND_WAIT;
         ST_OPERAND_WAIT: state_nx = ST_EXECUTE;
         ST_EXECUTE:      state_nx = (held_opc == OPC_STOR) ? ST_STORE : ST_FETCH_ADDR;
         ST_STORE:        state_nx = ST_FETCH_ADDR;
         ST_HALT:         state_nx = ST_HALT;
         default:         state_nx = ST_HALT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_FETCH_ADDR;
         bad_opc <= 1'b0;
      end else begin
         state <= state_nx;
         if (state == ST_DECODE && !opc_defined(fetched_opc))
            bad_opc <= 1'b1;
      end
   end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int MUL_STYLE = 0
) (
   input  logic [OPC_W-1:0]  opc,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] result
);

   logic [DATA_W-1:0] product;

   generate
      if (MUL_STYLE == 0) begin : g_mul_native
         assign product = acc * opnd;
      end else begin : g_mul_shift_add
         always_comb begin
            product = '0;
            for (int b = 0; b < DATA_W; b++) begin
               if (opnd[b])
                  product = product + (acc << b);
            end
         end
      end
   endgenerate

   always_comb begin
      case (opc)
         OPC_ADD: result = acc + opnd;
         OPC_MUL: result = product;
         default: result = opnd;
      endcase
   end

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 12,
   parameter int START_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cpu_state_e        state,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] alu_result,
   output logic [DATA_W-1:0] ir,
   output logic [ADDR_W-1:0] mar,
   output logic [DATA_W-1:0] mdr,
   output logic [DATA_W-1:0] tmp,
   output logic [DATA_W-1:0] acc
);

   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_ADDR);

   logic [ADDR_W-1:0] pc;
   logic [OPC_W-1:0]  ir_opc;

   assign ir_opc = ir[DATA_W-1 -: OPC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc  <= PC_RST;
         ir  <= '0;
         mar <= '0;
         mdr <= '0;
         tmp <= '0;
         acc <= '0;
      end else begin
         case (state)
            ST_FETCH_ADDR: mar <= pc;
            ST_DECODE: begin
               ir  <= rdata;
               mdr <= rdata;
               pc  <= pc + 1'b1;
               mar <= rdata[ADDR_W-1:0];
            end
            ST_OPERAND_WAIT: begin
               mdr <= rdata;
               tmp <= rdata;
            end
            ST_EXECUTE: begin
               case (ir_opc)
                  OPC_LOAD, OPC_ADD, OPC_MUL: acc <= alu_result;
                  OPC_STOR:                   mdr <= acc;
                  OPC_JUMP:                   pc  <= ir[ADDR_W-1:0];
                  default:                    ;
               endcase
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int  DATA_W     = 16,
   parameter int  START_ADDR = 0,
   parameter int  MUL_STYLE  = 0,
   localparam int ADDR_W     = DATA_W - OPC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              halted,
   output logic              illegal
);

   generate
      if (DATA_W < OPC_W + 2) begin : g_bad_width
         $error("acc_cpu_core: DATA_W too small for opcode plus address");
      end
      if (START_ADDR < 0 || START_ADDR >= (1 << ADDR_W)) begin : g_bad_start
         $error("acc_cpu_core: START_ADDR outside address space");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_mul
         $error("acc_cpu_core: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   cpu_state_e        state;
   logic              bad_opc;
   logic [DATA_W-1:0] ir, mdr, tmp, acc, alu_result;
   logic [ADDR_W-1:0] mar;
   logic [OPC_W-1:0]  ir_opc;

   assign ir_opc = ir[DATA_W-1 -: OPC_W];

   acc_cpu_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetched_opc (mem_rdata[DATA_W-1 -: OPC_W]),
      .held_opc    (ir_opc),
      .state       (state),
      .bad_opc     (bad_opc)
   );

   acc_cpu_dp #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR)
   ) u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (state),
      .rdata      (mem_rdata),
      .alu_result (alu_result),
      .ir         (ir),
      .mar        (mar),
      .mdr        (mdr),
      .tmp        (tmp),
      .acc        (acc)
   );

   acc_cpu_alu #(
      .DATA_W    (DATA_W),
      .MUL_STYLE (MUL_STYLE)
   ) u_alu (
      .opc    (ir_opc),
      .acc    (acc),
      .opnd   (tmp),
      .result (alu_result)
   );

   assign mem_addr  = mar;
   assign mem_wdata = mdr;
   assign mem_rd    = (state == ST_FETCH_WAIT) || (state == ST_OPERAND_ADDR);
   assign mem_wr    = (state == ST_STORE);
   assign halted    = (state == ST_HALT);
   assign illegal   = bad_opc;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk (
   input logic clk,
   input logic rst_n,
   input logic mem_rd,
   input logic mem_wr,
   input logic halted,
   input logic illegal
);

   // R12
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R12
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   // R7
   wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);

   // R9
   wr_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(mem_rd, 3));

   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   // R10
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_rd && !mem_wr));

   // R11
   bad_opc_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted);

   // R11
   bad_opc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(illegal));

endmodule

bind acc_cpu_core acc_cpu_core_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mem_rd  (mem_rd),
   .mem_wr  (mem_wr),
   .halted  (halted),
   .illegal (illegal)
);

// File: tb/acc_cpu_core_tb.sv
`timescale 1ns/1ps
module acc_cpu_core_tb;

   localparam logic [11:0] S  = 12'h040;
   localparam logic [11:0] DA = 12'h200;
   localparam logic [11:0] DB = 12'h201;
   localparam logic [11:0] DC = 12'h202;

   // {opcode, word at DA, word at DB, expected stored result}
   localparam logic [51:0] VEC [0:5] = '{
      {4'h2, 16'd4,    16'd6,    16'd10},
      {4'h2, 16'hFFFF, 16'h0002, 16'h0001},
      {4'h3, 16'd5,    16'd10,   16'd50},
      {4'h3, 16'h1234, 16'h0100, 16'h3400},
      {4'h3, 16'hFFFF, 16'hFFFF, 16'h0001},
      {4'h1, 16'h1111, 16'h0BCD, 16'h0BCD}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr, halted, illegal;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   logic [15:0] mem [0:4095];
   logic [11:0] rlog [0:31];
   int          rcnt, wcnt;
   logic [11:0] wa_last;
   logic [15:0] wd_last;
   logic        overlap, dbl_rd, prev_rd;

   always #10 clk = ~clk;

   acc_cpu_core #(.START_ADDR(int'(S))) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .halted    (halted),
      .illegal   (illegal)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         rcnt <= 0; wcnt <= 0; overlap <= 1'b0; dbl_rd <= 1'b0; prev_rd <= 1'b0;
      end else begin
         prev_rd <= mem_rd;
         if (mem_rd && mem_wr) overlap <= 1'b1;
         if (mem_rd && prev_rd) dbl_rd <= 1'b1;
         if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            if (rcnt < 32) rlog[rcnt[4:0]] <= mem_addr;
            rcnt <= rcnt + 1;
         end
         if (mem_wr) begin
            wa_last <= mem_addr; wd_last <= mem_wdata; wcnt <= wcnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic fill_mem();
      for (int a = 0; a < 4096; a++) mem[a] = 16'hBEEF;
   endtask

   task automatic run(output int n);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      n = 0;
      while (!halted && n < 500) begin
         @(negedge clk);
         n++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++; checks++;
         $display("FAIL watchdog: actual %0d expected <150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int n, rc0, wc0;
      string tg;

      // Vector table: load, operate, store, stop
      for (int i = 0; i < 6; i++) begin
         fill_mem();
         mem[S]   = {4'h1, DA};
         mem[S+1] = {VEC[i][51:48], DB};
         mem[S+2] = {4'h4, DC};
         mem[S+3] = 16'h0000;
         mem[DA]  = VEC[i][47:32];
         mem[DB]  = VEC[i][31:16];
         run(n);
         tg = (VEC[i][51:48] == 4'h2) ? "R5" : (VEC[i][51:48] == 4'h3) ? "R6" : "R4";
         chk(tg, wd_last, VEC[i][15:0]);
         chk("R7 addr", wa_last, DC);
         chk("R7 count", wcnt, 1);
         chk("R9 cycles", n, 20);
         chk("R3 legal", illegal, 0);
         chk("R2 fetch0", rlog[0], S);
         chk("R2 opnd0", rlog[1], DA);
         chk("R2 fetch1", rlog[2], S + 1);
         chk("R2 opnd1", rlog[3], DB);
         chk("R2 fetch2", rlog[4], S + 2);
         chk("R2 fetch3", rlog[5], S + 3);
         chk("R2 reads", rcnt, 6);
      end

      // R1: reset clears a halted core, accumulator reads back as zero
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 halted", halted, 0);
      chk("R1 illegal", illegal, 0);
      chk("R1 rd", mem_rd, 0);
      chk("R1 wr", mem_wr, 0);
      chk("R1 addr", mem_addr, 0);
      fill_mem();
      mem[S]   = {4'h4, 12'h300};
      mem[S+1] = 16'h0000;
      run(n);
      chk("R1 acc zero", wd_last, 0);
      chk("R1 start", rlog[0], S);
      chk("R7 store addr", wa_last, 12'h300);
      chk("R9 store cycles", n, 8);

      // R8: jump redirects fetch, skipped store never happens
      fill_mem();
      mem[S]      = {4'h5, 12'h0A0};
      mem[S+1]    = {4'h4, 12'h301};
      mem[12'h0A0] = {4'h1, DA};
      mem[12'h0A1] = {4'h4, 12'h302};
      mem[12'h0A2] = 16'h0000;
      mem[DA]     = 16'h5A5A;
      run(n);
      chk("R8 target fetch", rlog[1], 12'h0A0);
      chk("R8 reads", rcnt, 5);
      chk("R8 writes", wcnt, 1);
      chk("R8 store addr", wa_last, 12'h302);
      chk("R8 data", wd_last, 16'h5A5A);
      chk("R9 jump cycles", n, 18);

      // R10: stopped core stays quiet
      rc0 = rcnt; wc0 = wcnt;
      repeat (20) @(negedge clk);
      chk("R10 halted", halted, 1);
      chk("R10 illegal", illegal, 0);
      chk("R10 reads", rcnt, rc0);
      chk("R10 writes", wcnt, wc0);

      // R11: undefined opcodes at both ends of the range
      fill_mem();
      mem[S] = 16'h6123;
      run(n);
      chk("R11 illegal op6", illegal, 1);
      chk("R11 halted op6", halted, 1);
      chk("R9 stop cycles", n, 3);
      chk("R11 no write", wcnt, 0);
      fill_mem();
      mem[S] = 16'hF000;
      run(n);
      chk("R11 illegal opF", illegal, 1);
      repeat (5) @(negedge clk);
      chk("R11 sticky", illegal, 1);
      chk("R11 reads", rcnt, 1);

      // R12: bus exclusivity seen across the last run and a full program
      fill_mem();
      mem[S] = {4'h1, DA}; mem[S+1] = {4'h3, DB}; mem[S+2] = {4'h4, DC};
      mem[S+3] = {4'h5, S + 12'd4}; mem[S+4] = 16'h0000;
      mem[DA] = 16'd7; mem[DB] = 16'd3;
      run(n);
      chk("R12 overlap", overlap, 0);
      chk("R12 double read", dbl_rd, 0);
      chk("R6 chained", wd_last, 16'd21);
      chk("R9 mixed cycles", n, 24);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule